// File: doc/BRIEF.md
# Serial Flash Clock and Select Sequencer

This block turns a fast reference clock into the serial clock and the four active-low select lines of a serial flash port. A frame request carrying a bit count starts a frame. The block first drives the select lines and holds the serial clock at its rest level for a programmed setup delay. It then toggles the clock for two edges per bit and holds select for a programmed hold delay. After that it releases select and keeps it released for a minimum deselect time before the next frame may begin. A data shifter beside it gets two single-cycle strobes, one marking when to drive the next bit and one marking when to sample. Their placement follows the phase setting.

The configuration is sampled into a shadow copy only while the block is disabled and no frame or deselect interval is in progress. A frame therefore always runs with one consistent set of timings. The clock divisor is a 4-bit value N, and each half period of the serial clock lasts N+1 reference cycles. Four 8-bit delays shape the select timing. A 4-bit select code is either driven straight onto the select lines or marked as an encoded value for a decoder outside the block.

Top module: `flash_sclk_timing`

## Requirements
- R1: After synchronous reset, `idle` is 1, `cs_n` is 4'hF, `sclk` is 0 and both strobes are 0. The shadow configuration resets to divisor 0, polarity 0, phase 0, select code 4'hF, decode off and all delays 0.
- R2: The configuration inputs are copied into the shadow only on clock edges where `enable` is 0 and `idle` is 1. Changes made while `enable` is 1 have no effect on any frame.
- R3: While the clock toggles, each half period lasts N+1 reference cycles, so one serial clock period is 2*(N+1) reference cycles (even ratios 2 to 32).
- R4: `sclk` equals the polarity setting in every cycle outside the toggling phase. The first edge of a frame moves it away from that level, and the last edge returns it there.
- R5: Select is asserted for `cfg_dly_pre`+1 cycles before the first clock edge. A valid request accepted on an edge asserts select in the next cycle.
- R6: After the final half period (N+1 cycles), select stays asserted for `cfg_dly_post`+1 more cycles.
- R7: After select is released, it stays released for max(`cfg_dly_gap`, `cfg_dly_same`)+1 cycles, and `idle` stays 0 during that time. A valid request that arrives in that window is held, and its frame asserts select in the cycle right after the window ends.
- R8: While a frame holds select, `cs_n` equals the 4-bit select code. Device i is chosen in direct mode by clearing bit i only, for example device 0 is 4'b1110 and device 3 is 4'b0111. Outside a frame `cs_n` is 4'hF. `cs_encoded` reflects the decode setting.
- R9: With phase 0, `launch_stb` pulses in the first select cycle and on every trailing edge except the last, and `capture_stb` pulses on every leading edge. Leading edges are the odd-numbered edges, counting from 1.
- R10: With phase 1, `launch_stb` pulses on every leading edge and `capture_stb` pulses on every trailing edge.
- R11: A request is ignored when `frame_bits` is 0, when `enable` is 0 in idle, or while select is asserted.
- R12: A frame of B bits produces exactly 2*B transitions of `sclk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; configuration loads while low |
| cfg_div | input | 4 | Half-period length minus one |
| cfg_cpol | input | 1 | Clock rest level |
| cfg_cpha | input | 1 | Clock phase setting |
| cfg_cs_code | input | 4 | Select value driven during a frame |
| cfg_cs_decode | input | 1 | Select value is an encoded device number |
| cfg_dly_pre | input | 8 | Select-to-first-edge delay |
| cfg_dly_post | input | 8 | Last-edge-to-release delay |
| cfg_dly_same | input | 8 | Back-to-back deselect delay |
| cfg_dly_gap | input | 8 | Minimum release time |
| frame_req | input | 1 | Single-cycle frame request |
| frame_bits | input | BITS_W | Bits in the requested frame |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low select lines |
| cs_encoded | output | 1 | Marks cs_n as an encoded value |
| launch_stb | output | 1 | Drive-next-bit strobe |
| capture_stb | output | 1 | Sample-bit strobe |
| idle | output | 1 | No frame or release interval active |

## Verification
The assertions assume that the configuration inputs only matter through the shadow copy. They also assume a frame's bit count is fixed when the request is accepted, so the spacing of edges and the phase order can be checked against one constant divisor. The stimulus changes the configuration only while `enable` is low. The one exception is a deliberate change while enabled, made to show that it has no effect. Requests are single-cycle pulses driven away from the active edge. They include zero-length requests, requests while disabled, requests during a frame and requests during the release window.

// File: rtl/sct_pkg.sv
package sct_pkg;

    parameter int unsigned SCT_DIV_W = 4;
    parameter int unsigned SCT_DLY_W = 8;
    parameter int unsigned SCT_CS_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_RUN  = 3'd2,
        PH_POST = 3'd3,
        PH_GAP  = 3'd4
    } sct_phase_e;

    typedef struct packed {
        logic [SCT_DIV_W-1:0] div;
        logic                 cpol;
        logic                 cpha;
        logic [SCT_CS_W-1:0]  cs_code;
        logic                 decode;
        logic [SCT_DLY_W-1:0] d_pre;
        logic [SCT_DLY_W-1:0] d_post;
        logic [SCT_DLY_W-1:0] d_same;
        logic [SCT_DLY_W-1:0] d_gap;
    } sct_cfg_t;

    typedef struct packed {
        sct_phase_e phase;
        logic       edge_now;
        logic       odd_half;
        logic       last_half;
        logic       pre_first;
    } sct_tick_t;

    function automatic logic [SCT_DLY_W-1:0] sct_max(
        input logic [SCT_DLY_W-1:0] a,
        input logic [SCT_DLY_W-1:0] b
    );
        return (a > b) ? a : b;
    endfunction

    function automatic sct_cfg_t sct_cfg_reset();
        sct_cfg_t c;
        c         = '0;
        c.cs_code = '1;
        return c;
    endfunction

endpackage

// File: rtl/sct_cfg_shadow.sv
module sct_cfg_shadow
    import sct_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  sct_cfg_t cfg_in,
    output sct_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= sct_cfg_reset();
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/sct_seq.sv
module sct_seq
    import sct_pkg::*;
#(
    parameter int unsigned BITS_W = 6
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  sct_cfg_t          cfg,
    input  logic              req,
    input  logic [BITS_W-1:0] bits,
    output sct_tick_t         tick,
    output logic              idle
);

    localparam int unsigned HALF_W = BITS_W + 1;

    sct_phase_e           st;
    logic [SCT_DLY_W-1:0] cnt;
    logic [HALF_W-1:0]    half_idx;
    logic [HALF_W-1:0]    half_last;
    logic                 pend;
    logic [BITS_W-1:0]    pend_bits;
    logic                 req_ok;
    logic [SCT_DLY_W-1:0] div_ext;

    assign req_ok  = req && enable && (bits != '0);
    assign div_ext = SCT_DLY_W'(cfg.div);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PH_IDLE;
            cnt       <= '0;
            half_idx  <= '0;
            half_last <= '0;
            pend      <= 1'b0;
            pend_bits <= '0;
        end else begin
            case (st)
                PH_IDLE: begin
                    if (req_ok) begin
                        st        <= PH_PRE;
                        cnt       <= cfg.d_pre;
                        half_last <= {bits, 1'b0} - HALF_W'(1);
                    end
                end
                PH_PRE: begin
                    if (cnt == '0) begin
                        st       <= PH_RUN;
                        cnt      <= div_ext;
                        half_idx <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RUN: begin
                    if (cnt == '0) begin
                        if (half_idx == half_last) begin
                            st  <= PH_POST;
                            cnt <= cfg.d_post;
                        end else begin
                            half_idx <= half_idx + 1'b1;
                            cnt      <= div_ext;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_POST: begin
                    if (cnt == '0) begin
                        st  <= PH_GAP;
                        cnt <= sct_max(cfg.d_gap, cfg.d_same);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_GAP: begin
                    if (cnt == '0) begin
                        if (pend) begin
                            st        <= PH_PRE;
                            cnt       <= cfg.d_pre;
                            half_last <= {pend_bits, 1'b0} - HALF_W'(1);
                            pend      <= 1'b0;
                        end else if (req_ok) begin
                            st        <= PH_PRE;
                            cnt       <= cfg.d_pre;
                            half_last <= {bits, 1'b0} - HALF_W'(1);
                        end else begin
                            st <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                        if (req_ok && !pend) begin
                            pend      <= 1'b1;
                            pend_bits <= bits;
                        end
                    end
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        tick.phase     = st;
        tick.edge_now  = (st == PH_RUN) && (cnt == div_ext);
        tick.odd_half  = half_idx[0];
        tick.last_half = (half_idx == half_last);
        tick.pre_first = (st == PH_PRE) && (cnt == cfg.d_pre);
    end

    assign idle = (st == PH_IDLE);

    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st == PH_RUN) |-> (cnt <= div_ext)); // R3
    AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick.edge_now && cfg.div != '0) |=> !tick.edge_now); // R3
    AST_POST_TO_GAP: assert property (@(posedge clk) disable iff (rst)
        (st == PH_POST) |=> (st == PH_POST || st == PH_GAP)); // R6
    AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st == PH_GAP && cnt != '0) |=> (st == PH_GAP)); // R7

endmodule

// File: rtl/sct_pins.sv
module sct_pins
    import sct_pkg::*;
(
    input  sct_cfg_t            cfg,
    input  sct_tick_t           tick,
    output logic                sclk,
    output logic [SCT_CS_W-1:0] cs_n,
    output logic                cs_encoded,
    output logic                launch_stb,
    output logic                capture_stb
);

    logic active;
    logic lead_edge;
    logic trail_edge;

    assign active     = (tick.phase == PH_PRE) || (tick.phase == PH_RUN) ||
                        (tick.phase == PH_POST);
    assign cs_n       = active ? cfg.cs_code : '1;
    assign cs_encoded = cfg.decode;
    assign sclk       = cfg.cpol ^ ((tick.phase == PH_RUN) & ~tick.odd_half);
    assign lead_edge  = tick.edge_now & ~tick.odd_half;
    assign trail_edge = tick.edge_now & tick.odd_half;

    always_comb begin
        if (cfg.cpha) begin
            launch_stb  = lead_edge;
            capture_stb = trail_edge;
        end else begin
            launch_stb  = tick.pre_first | (trail_edge & ~tick.last_half);
            capture_stb = lead_edge;
        end
    end

endmodule

// File: rtl/flash_sclk_timing.sv
module flash_sclk_timing
    import sct_pkg::*;
#(
    parameter int unsigned BITS_W = 6
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic [SCT_DIV_W-1:0] cfg_div,
    input  logic                 cfg_cpol,
    input  logic                 cfg_cpha,
    input  logic [SCT_CS_W-1:0]  cfg_cs_code,
    input  logic                 cfg_cs_decode,
    input  logic [SCT_DLY_W-1:0] cfg_dly_pre,
    input  logic [SCT_DLY_W-1:0] cfg_dly_post,
    input  logic [SCT_DLY_W-1:0] cfg_dly_same,
    input  logic [SCT_DLY_W-1:0] cfg_dly_gap,
    input  logic                 frame_req,
    input  logic [BITS_W-1:0]    frame_bits,
    output logic                 sclk,
    output logic [SCT_CS_W-1:0]  cs_n,
    output logic                 cs_encoded,
    output logic                 launch_stb,
    output logic                 capture_stb,
    output logic                 idle
);

    sct_cfg_t  cfg_in;
    sct_cfg_t  cfg_q;
    sct_tick_t tick;
    logic      seq_idle;

    always_comb begin
        cfg_in.div     = cfg_div;
        cfg_in.cpol    = cfg_cpol;
        cfg_in.cpha    = cfg_cpha;
        cfg_in.cs_code = cfg_cs_code;
        cfg_in.decode  = cfg_cs_decode;
        cfg_in.d_pre   = cfg_dly_pre;
        cfg_in.d_post  = cfg_dly_post;
        cfg_in.d_same  = cfg_dly_same;
        cfg_in.d_gap   = cfg_dly_gap;
    end

    sct_cfg_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (!enable && seq_idle),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    sct_seq #(.BITS_W(BITS_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .cfg    (cfg_q),
        .req    (frame_req),
        .bits   (frame_bits),
        .tick   (tick),
        .idle   (seq_idle)
    );

    sct_pins u_pins (
        .cfg         (cfg_q),
        .tick        (tick),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .cs_encoded  (cs_encoded),
        .launch_stb  (launch_stb),
        .capture_stb (capture_stb)
    );

    assign idle = seq_idle;

    AST_CLK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        (sclk != cfg_q.cpol) |-> (tick.phase == PH_RUN)); // R4
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(launch_stb && capture_stb)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        idle |-> (cs_n == '1 && !launch_stb && !capture_stb)); // R1

endmodule

// File: tb/flash_sclk_timing_test.sv
module flash_sclk_timing_test;

    localparam int BW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          enable;
    logic [3:0]    cfg_div;
    logic          cfg_cpol;
    logic          cfg_cpha;
    logic [3:0]    cfg_cs_code;
    logic          cfg_cs_decode;
    logic [7:0]    cfg_dly_pre;
    logic [7:0]    cfg_dly_post;
    logic [7:0]    cfg_dly_same;
    logic [7:0]    cfg_dly_gap;
    logic          frame_req;
    logic [BW-1:0] frame_bits;
    logic          sclk;
    logic [3:0]    cs_n;
    logic          cs_encoded;
    logic          launch_stb;
    logic          capture_stb;
    logic          idle;

    always #2 clk = ~clk;

    flash_sclk_timing #(.BITS_W(BW)) uut (
        .clk(clk), .rst(rst), .enable(enable),
        .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_cs_code(cfg_cs_code), .cfg_cs_decode(cfg_cs_decode),
        .cfg_dly_pre(cfg_dly_pre), .cfg_dly_post(cfg_dly_post),
        .cfg_dly_same(cfg_dly_same), .cfg_dly_gap(cfg_dly_gap),
        .frame_req(frame_req), .frame_bits(frame_bits),
        .sclk(sclk), .cs_n(cs_n), .cs_encoded(cs_encoded),
        .launch_stb(launch_stb), .capture_stb(capture_stb), .idle(idle)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit chk_on = 0;
    bit done = 0;

    // behavioural reference: frame timeline position plus shadow settings
    bit m_act, m_pend;
    int m_k, m_bits, m_pbits;
    int s_div, s_pre, s_post, s_same, s_gap, s_code;
    bit s_cpol, s_cpha, s_dec;

    // frame monitor
    bit in_fr = 0;
    int act_len = 0, edges = 0, hi_len = 0;
    int last_len = 0, last_edges = 0, last_hi = 0, frames_done = 0;
    logic prev_sclk = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int gmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_pend = 0; m_k = 0; m_bits = 0; m_pbits = 0;
            s_div = 0; s_pre = 0; s_post = 0; s_same = 0; s_gap = 0;
            s_code = 15; s_cpol = 0; s_cpha = 0; s_dec = 0;
        end else begin
            int tot, gs;
            bit ok_req;
            ok_req = frame_req && enable && (frame_bits != 0);
            if (!enable && !m_act) begin
                s_div = cfg_div; s_pre = cfg_dly_pre; s_post = cfg_dly_post;
                s_same = cfg_dly_same; s_gap = cfg_dly_gap; s_code = cfg_cs_code;
                s_cpol = cfg_cpol; s_cpha = cfg_cpha; s_dec = cfg_cs_decode;
            end
            if (m_act) begin
                gs  = (s_pre + 1) + 2 * m_bits * (s_div + 1) + (s_post + 1);
                tot = gs + gmax(s_gap, s_same) + 1;
                if (m_k == tot - 1) begin
                    if (m_pend) begin
                        m_bits = m_pbits; m_pend = 0; m_k = 0;
                    end else if (ok_req) begin
                        m_bits = frame_bits; m_k = 0;
                    end else begin
                        m_act = 0;
                    end
                end else begin
                    if (m_k >= gs && ok_req && !m_pend) begin
                        m_pend = 1; m_pbits = frame_bits;
                    end
                    m_k++;
                end
            end else if (ok_req) begin
                m_act = 1; m_k = 0; m_bits = frame_bits;
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            int h, p, r, gs, e_cs, e_sclk, j, o;
            bit e_l, e_c, lead;
            string tag;
            h = s_div + 1; p = s_pre + 1; r = 2 * m_bits * h;
            gs = p + r + s_post + 1;
            e_cs = 15; e_sclk = s_cpol; e_l = 0; e_c = 0; tag = "R1";
            if (m_act && m_k < gs) begin
                e_cs = s_code;
                if (m_k < p) begin
                    tag = "R5";
                    e_l = (s_cpha == 0) && (m_k == 0);
                end else if (m_k < p + r) begin
                    tag = "R3";
                    j = (m_k - p) / h; o = (m_k - p) % h;
                    e_sclk = s_cpol ^ ((j % 2) == 0);
                    if (o == 0) begin
                        lead = ((j % 2) == 0);
                        if (s_cpha == 0) begin
                            e_c = lead;
                            e_l = !lead && (j != 2 * m_bits - 1);
                        end else begin
                            e_l = lead;
                            e_c = !lead;
                        end
                    end
                end else begin
                    tag = "R6";
                end
            end else if (m_act) begin
                tag = "R7";
            end
            chk(cs_n == e_cs[3:0], tag, "cs_n (R8)", cs_n, e_cs);
            chk(sclk == e_sclk[0], "R4", "sclk", sclk, e_sclk);
            chk(launch_stb == e_l, s_cpha ? "R10" : "R9", "launch", launch_stb, e_l);
            chk(capture_stb == e_c, s_cpha ? "R10" : "R9", "capture", capture_stb, e_c);
            chk(idle == !m_act, tag, "idle", idle, !m_act);
            chk(cs_encoded == s_dec, "R8", "cs_encoded", cs_encoded, s_dec);

            if (cs_n != 4'hF) begin
                if (!in_fr) begin
                    in_fr = 1; act_len = 0; edges = 0; last_hi = hi_len;
                end
                act_len++;
                if (sclk != prev_sclk) edges++;
            end else begin
                if (in_fr) begin
                    in_fr = 0; last_len = act_len; last_edges = edges;
                    frames_done++; hi_len = 0;
                end
                hi_len++;
            end
            prev_sclk = sclk;
        end
    end

    task automatic send(input int nb);
        @(negedge clk);
        frame_req = 1'b1;
        frame_bits = nb[BW-1:0];
        @(negedge clk);
        frame_req = 1'b0;
    endtask

    task automatic wait_frame(input int f0);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #1;
            if (frames_done != f0) break;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int f0;
        rst = 1; enable = 0; frame_req = 0; frame_bits = '0;
        cfg_div = 0; cfg_cpol = 0; cfg_cpha = 0; cfg_cs_code = 4'hF;
        cfg_cs_decode = 0; cfg_dly_pre = 0; cfg_dly_post = 0;
        cfg_dly_same = 0; cfg_dly_gap = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk_on = 1;
        chk(idle == 1'b1, "R1", "reset idle", idle, 1);
        chk(cs_n == 4'hF, "R1", "reset cs_n", cs_n, 15);
        chk(sclk == 1'b0, "R1", "reset sclk", sclk, 0);

        // mode 0, direct select of device 0
        cfg_div = 1; cfg_cs_code = 4'b1110; cfg_dly_pre = 2; cfg_dly_post = 1;
        cfg_dly_gap = 3; cfg_dly_same = 5;
        repeat (2) @(negedge clk);
        enable = 1;
        f0 = frames_done;
        send(3);
        wait_frame(f0);
        chk(last_edges == 6, "R12", "edges B=3", last_edges, 6);
        chk(last_len == 17, "R5", "select length", last_len, 17);

        // back-to-back: second request lands in the release window
        f0 = frames_done;
        send(2);
        wait_frame(f0);
        f0 = frames_done;
        send(1);
        wait_frame(f0);
        chk(last_hi == 6, "R7", "release time", last_hi, 6);
        chk(last_edges == 2, "R12", "edges B=1", last_edges, 2);

        // mode 3, encoded select, zero delays
        repeat (10) @(negedge clk);
        enable = 0;
        cfg_div = 0; cfg_cpol = 1; cfg_cpha = 1; cfg_cs_code = 4'b0111;
        cfg_cs_decode = 1; cfg_dly_pre = 0; cfg_dly_post = 0;
        cfg_dly_gap = 0; cfg_dly_same = 0;
        repeat (2) @(negedge clk);
        enable = 1;
        f0 = frames_done;
        send(2);
        wait_frame(f0);
        chk(last_len == 6, "R3", "select length div0", last_len, 6);
        chk(cs_encoded == 1'b1, "R8", "encoded flag", cs_encoded, 1);

        // ignored requests
        f0 = frames_done;
        send(0);
        repeat (10) @(negedge clk);
        chk(frames_done == f0 && idle, "R11", "zero-bit request", frames_done, f0);
        enable = 0;
        send(3);
        repeat (10) @(negedge clk);
        chk(frames_done == f0 && idle, "R11", "disabled request", frames_done, f0);
        enable = 1;
        send(4);
        repeat (3) @(negedge clk);
        send(1);
        repeat (30) @(negedge clk);
        chk(frames_done == f0 + 1, "R11", "request during frame", frames_done, f0 + 1);

        // configuration change while enabled has no effect
        cfg_div = 3; cfg_dly_pre = 7;
        repeat (2) @(negedge clk);
        f0 = frames_done;
        send(1);
        wait_frame(f0);
        chk(last_len == 4, "R2", "old timing kept", last_len, 4);
        enable = 0;
        repeat (3) @(negedge clk);
        enable = 1;
        f0 = frames_done;
        send(1);
        wait_frame(f0);
        chk(last_len == 17, "R2", "new timing after reload", last_len, 17);

        // slowest divisor, mode 2, device 2
        repeat (5) @(negedge clk);
        enable = 0;
        cfg_div = 15; cfg_cpol = 1; cfg_cpha = 0; cfg_cs_code = 4'b1011;
        cfg_cs_decode = 0; cfg_dly_pre = 1; cfg_dly_post = 2;
        repeat (2) @(negedge clk);
        enable = 1;
        f0 = frames_done;
        send(2);
        wait_frame(f0);
        chk(last_len == 69, "R3", "select length div15", last_len, 69);
        chk(last_edges == 4, "R12", "edges B=2", last_edges, 4);
        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule